// File: doc/BRIEF.md
# Two-Channel Wavelet Analysis Stage (Polyphase, Transposed Form)

This block splits one stream of signed 12-bit fixed-point samples into two half-rate streams: a low-pass approximation and a high-pass detail. It forms one level of a wavelet decomposition tree. Several copies can be chained, with the low output of one stage feeding the next, to build an octave-band filter bank.

Each filter has eight Daubechies-4 taps. Decimation is done before filtering: even-indexed and odd-indexed samples each drive a four-tap transposed-form branch, and the two branch results are added once for every pair of samples. The filters therefore run at half the input rate, and no result is computed only to be thrown away. Products and sums are kept at full precision and then cut back to the input format.

Samples are counted from 0 after reset. A sample is accepted on each clock edge where `inValid` is high. Sample 0 and every later even-numbered sample is held. Each odd-numbered sample completes a pair and produces one output pair.

Top module: `dwtHalfbandStage`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `outValid` is 0 and `loOut` and `hiOut` are 0. All filter history is cleared, so samples from before reset have no effect.
- R2: `outValid` is a one-cycle pulse. It is high in the cycle after the clock edge that accepts an odd-numbered sample (1, 3, 5, ...). It is never high in any other cycle.
- R3: Cycles with `inValid` low are ignored. They do not change the sample count, they raise no `outValid`, and they change no output.
- R4: Low-pass output. For pair m, let n = 2m+1. Then `loOut` is the truncated value of the sum over k = 0..7 of h[k]·x[n-k], where x before sample 0 counts as 0. The values of h[0..7] in Q1.11 integers are -22, 67, 63, -383, -57, 1292, 1464, 472.
- R5: High-pass output. For the same pair m, `hiOut` uses g[k] = (-1)^k · h[7-k], which gives 472, -1464, 1292, 57, -383, -63, 67, 22.
- R6: Inputs and coefficients are Q1.11, with integer value = real × 2048. The 27-bit Q5.22 sum is cut to Q1.11 by taking bits [22:11]. There is no rounding and no saturation, so negative fractions round toward minus infinity and large sums wrap.
- R7: Right after reset, each output uses only the samples accepted since reset. An impulse of amplitude A at sample 0 gives loOut[m] = trunc(h[2m+1]·A) and hiOut[m] = trunc(g[2m+1]·A) for m = 0..3. After that, both outputs are 0.
- R8: Between `outValid` pulses, `loOut` and `hiOut` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | The sample on `inSample` is accepted this cycle |
| inSample | input | 12 | Signed Q1.11 input sample |
| outValid | output | 1 | One-cycle strobe: a new output pair is present |
| loOut | output | 12 | Signed Q1.11 low-pass (approximation) output |
| hiOut | output | 12 | Signed Q1.11 high-pass (detail) output |

## Verification
The assertions assume that `inValid` and `inSample` are never unknown once reset has been released. The bench keeps to this by driving both from tasks on the falling edge, with `inValid` held low between samples. The assertions make no assumption about sample values or about the spacing between samples. The stimulus therefore covers back-to-back samples, irregular idle gaps, full-scale values of both signs and an impulse, so that the results exercise wraparound and rounding toward minus infinity.

// File: rtl/dwtStagePkg.sv
package dwtStagePkg;
  localparam int DATA_W = 12;
  localparam int FRAC_W = 11;
  localparam int TAPS   = 8;
  localparam int BR_TAPS = TAPS / 2;
  localparam int PROD_W = 2 * DATA_W;
  localparam int ACC_W  = PROD_W + $clog2(TAPS);

  typedef logic signed [DATA_W-1:0] sampleT;
  typedef logic signed [ACC_W-1:0]  accT;

  typedef struct packed {
    logic holdEven;
    logic firePair;
  } strobeT;

  // Daubechies-4 low-pass taps, Q1.11
  localparam sampleT LO_TAPS [TAPS] = '{
    -12'sd22, 12'sd67, 12'sd63, -12'sd383,
    -12'sd57, 12'sd1292, 12'sd1464, 12'sd472
  };

  function automatic sampleT loTap(input int k);
    return LO_TAPS[k];
  endfunction

  // mirrored taps with alternating sign
  function automatic sampleT hiTap(input int k);
    sampleT c;
    c = LO_TAPS[TAPS-1-k];
    return (k % 2 == 0) ? c : -c;
  endfunction
endpackage

// File: rtl/dwtStageCtrl.sv
module dwtStageCtrl
  import dwtStagePkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   inValid,
  output strobeT strobes
);
  logic phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= 1'b0;
    end else if (inValid) begin
      phase <= ~phase;
    end
  end

  always_comb begin
    strobes.holdEven = inValid & ~phase;
    strobes.firePair = inValid &  phase;
  end

  AST_PHASE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(phase)); // R3
  AST_PAIR_SPACED: assert property (@(posedge clk) disable iff (rst)
    strobes.firePair |=> !strobes.firePair); // R2
endmodule

// File: rtl/dwtTfBranch.sv
module dwtTfBranch
  import dwtStagePkg::*;
#(
  parameter int NT = BR_TAPS
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   en,
  input  sampleT sample,
  input  sampleT coef [NT],
  output accT    headSum
);
  accT prod  [NT];
  accT state [NT];

  genvar j;
  generate
    for (j = 0; j < NT; j++) begin : g_mul
      assign prod[j] = ACC_W'(sample * coef[j]);
    end

    assign state[0] = '0;

    for (j = 1; j < NT; j++) begin : g_reg
      if (j == NT - 1) begin : g_last
        always_ff @(posedge clk) begin
          if (rst) state[j] <= '0;
          else if (en) state[j] <= prod[j];
        end
      end else begin : g_mid
        always_ff @(posedge clk) begin
          if (rst) state[j] <= '0;
          else if (en) state[j] <= prod[j] + state[j+1];
        end
      end
    end
  endgenerate

  assign headSum = prod[0] + state[1];
endmodule

// File: rtl/dwtStageDatapath.sv
module dwtStageDatapath
  import dwtStagePkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  strobeT strobes,
  input  sampleT inSample,
  output logic   outValid,
  output sampleT loOut,
  output sampleT hiOut
);
  sampleT evenHold;
  accT    head [2][2];   // [filter 0=lo 1=hi][phase 0=even 1=odd]
  accT    total [2];
  sampleT trunc [2];

  always_ff @(posedge clk) begin
    if (rst) evenHold <= '0;
    else if (strobes.holdEven) evenHold <= inSample;
  end

  genvar f, p, j;
  generate
    for (f = 0; f < 2; f++) begin : g_filt
      for (p = 0; p < 2; p++) begin : g_phase
        sampleT coefs [BR_TAPS];
        for (j = 0; j < BR_TAPS; j++) begin : g_coef
          // even samples meet odd tap indices, odd samples even indices
          localparam int K = 2 * j + (1 - p);
          assign coefs[j] = (f == 0) ? loTap(K) : hiTap(K);
        end
        dwtTfBranch #(.NT(BR_TAPS)) u_br (
          .clk    (clk),
          .rst    (rst),
          .en     (strobes.firePair),
          .sample ((p == 0) ? evenHold : inSample),
          .coef   (coefs),
          .headSum(head[f][p])
        );
      end
      assign total[f] = head[f][0] + head[f][1];
      assign trunc[f] = total[f][FRAC_W+DATA_W-1:FRAC_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      loOut    <= '0;
      hiOut    <= '0;
    end else begin
      outValid <= strobes.firePair;
      if (strobes.firePair) begin
        loOut <= trunc[0];
        hiOut <= trunc[1];
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    strobes.firePair |=> outValid); // R2
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> ($stable(loOut) && $stable(hiOut))); // R8
endmodule

// File: rtl/dwtHalfbandStage.sv
module dwtHalfbandStage
  import dwtStagePkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] inSample,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] loOut,
  output logic signed [DATA_W-1:0] hiOut
);
  strobeT strobes;

  dwtStageCtrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .inValid(inValid),
    .strobes(strobes)
  );

  dwtStageDatapath u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .inSample(inSample),
    .outValid(outValid),
    .loOut   (loOut),
    .hiOut   (hiOut)
  );

  AST_VALID_SOURCE: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(inValid)); // R2
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    outValid |=> !outValid); // R2
endmodule

// File: tb/sim_dwtHalfbandStage.sv
module sim_dwtHalfbandStage;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic signed [11:0] inSample = '0;
  logic outValid;
  logic signed [11:0] loOut, hiOut;

  int nTests = 0;
  int nFail = 0;
  int hist [0:1023];
  int count = 0;
  logic signed [11:0] lastLo = '0, lastHi = '0;
  int H [8] = '{-22, 67, 63, -383, -57, 1292, 1464, 472};

  always #5 clk = ~clk;

  dwtHalfbandStage u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inSample(inSample),
    .outValid(outValid), .loOut(loOut), .hiOut(hiOut)
  );

  function automatic logic signed [11:0] expOut(input int n, input bit hi);
    longint acc = 0;
    logic signed [26:0] a;
    for (int k = 0; k < 8; k++) begin
      int c;
      c = hi ? ((k % 2) ? -H[7-k] : H[7-k]) : H[k];
      if (n - k >= 0) acc += longint'(c) * hist[n-k];
    end
    a = acc[26:0];
    return a[22:11];
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; inValid = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    count = 0; lastLo = '0; lastHi = '0;
  endtask

  // push one sample at a falling edge, check at the next falling edge
  task automatic push(input int x, input string req);
    inSample = 12'(x); inValid = 1'b1;
    hist[count] = $signed(12'(x));
    @(negedge clk);
    inValid = 1'b0;
    if (count % 2 == 1) begin
      logic signed [11:0] eLo, eHi;
      eLo = expOut(count, 1'b0);
      eHi = expOut(count, 1'b1);
      check("R2", "outValid on pair", int'(outValid), 1);
      check(req, "loOut (R4)", int'(loOut), int'(eLo));
      check(req, "hiOut (R5)", int'(hiOut), int'(eHi));
      lastLo = eLo; lastHi = eHi;
    end else begin
      check("R2", "outValid on even sample", int'(outValid), 0);
      check("R8", "loOut hold", int'(loOut), int'(lastLo));
      check("R8", "hiOut hold", int'(hiOut), int'(lastHi));
    end
    count++;
  endtask

  task automatic idle(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      inSample = 12'(i * 97 - 700);
      @(negedge clk);
      check("R3", "outValid idle", int'(outValid), 0);
      check("R3", "loOut idle", int'(loOut), int'(lastLo));
      check("R3", "hiOut idle", int'(hiOut), int'(lastHi));
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1", "outValid in reset", int'(outValid), 0);
    check("R1", "loOut in reset", int'(loOut), 0);
    check("R1", "hiOut in reset", int'(hiOut), 0);
    doReset();
    check("R1", "outValid after reset", int'(outValid), 0);
    check("R1", "loOut after reset", int'(loOut), 0);
  endtask

  task automatic testImpulse();
    doReset();
    push(2047, "R7");
    for (int i = 1; i < 12; i++) push(0, "R7");
  endtask

  task automatic testRamp();
    doReset();
    for (int i = 0; i < 24; i++) push(i * 150 - 1800, "R4");
  endtask

  task automatic testExtremes();
    doReset();
    for (int i = 0; i < 20; i++) push((i % 3 == 0) ? -2048 : 2047, "R6");
    for (int i = 0; i < 12; i++) push((i % 2) ? -2048 : -2048, "R6");
    for (int i = 0; i < 12; i++) push(i * 37 - 211, "R6");
  endtask

  task automatic testHistoryCleared();
    doReset();
    for (int i = 0; i < 9; i++) push(1900 - i * 300, "R1");
    doReset();
    push(500, "R1");
    push(-300, "R1");
    push(0, "R1");
    push(0, "R1");
  endtask

  task automatic testGaps();
    doReset();
    for (int i = 0; i < 16; i++) begin
      push((i * 523) % 4096 - 2048, "R5");
      idle(i % 4);
    end
  endtask

  initial begin
    testReset();
    testImpulse();
    testRamp();
    testExtremes();
    testHistoryCleared();
    testGaps();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule